// File: doc/BRIEF.md
# Register-Mapped Serial Port With Sticky Status

This block is a byte-wide asynchronous serial port. Software sees it as a small window of 32-bit words: received byte, byte to send, status, control, bit-period divisor and a spare end-of-packet word. The transmitter shifts out one frame per accepted write. The receiver samples the incoming line in the middle of each bit and holds exactly one received byte. Frames have one low start bit, eight data bits sent least significant bit first, and one high stop bit. The divisor sets how many clock cycles each bit lasts.

Status reports transmitter and receiver readiness, and it keeps sticky error flags until software reads the status word. A single level interrupt is raised whenever a status condition is set and its enable bit is set in control. Some control bits only store a value and do nothing else: line break output, request-to-send and end-of-packet enable. The end-of-packet word is also storage only. No parity is generated or checked. The modem-status bits always read as zero.

Read data is driven combinationally from the current register contents. Read side effects, such as clearing a flag, take place at the clock edge where `rdEn` is high.

Top module: `mmio_serial_port`

## Requirements
- R1: The register index is byte address bits [4:2], and address bits [1:0] are ignored. The indices are: 0 received byte, 1 transmit byte, 2 status, 3 control, 4 divisor, 5 end-of-packet word. Indices 6 and 7 read as zero.
- R2: After reset, status reads 0x60, control reads 0, divisor reads the reset parameter value, `irq` is low and `txLine` is high.
- R3: `irq` is high exactly when status AND control has a set bit among bits 0–8 and 10. Control bits 9, 11 and 12 never raise it. Status bit 5 is transmitter empty, bit 6 is transmit ready and bit 7 is receive ready.
- R4: Reading index 0 returns the held byte in bits [7:0] and clears receive ready (status bit 7).
- R5: Reading status clears framing error (bit 1), break (bit 2), receive overrun (bit 3), transmit overrun (bit 4) and any-error (bit 8). Receive ready is left unchanged.
- R6: Writes to index 0 and index 2 change nothing.
- R7: A write to index 1 while the transmitter is idle sends a frame of its low 8 bits: start 0, data LSB first, stop 1. Each bit lasts divisor+1 cycles. Status bits 5 and 6 are low while the frame is in progress. The line is high when idle.
- R8: A write to index 1 while a frame is in progress is dropped and sets transmit overrun (bit 4).
- R9: A completed incoming frame is stored and sets receive ready, but only if receive ready is clear or the byte is being read in that cycle. Otherwise the new byte is discarded, the held byte is kept and receive overrun (bit 3) is set.
- R10: A stop bit sampled low sets framing error (bit 1). If the data byte of that frame is also zero, break (bit 2) is set as well. Bit 8 is the OR of bits 0–4.
- R11: Control stores bits [12:0], the divisor stores its low bits and the end-of-packet word stores all 32 bits. Each reads back what was stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address of the access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; its side effects happen at the clock edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt level |
| rxLine | input | 1 | Serial input, asynchronous |
| txLine | output | 1 | Serial output |

## Verification
The main sweep loops the serial output back to the input and sends all 256 byte values. For each byte it checks receive ready, the interrupt, the received byte and the clearing of ready on read. This separates any bit-order or bit-drop fault from a fault in handshake timing. A set of bytes with contrasting bit patterns (all zeros, all ones, alternating bits, single bits) is checked bit by bit on the output line at two divisor settings. This tells a wrong bit period apart from a wrong bit position. Frames driven by the bench with a low stop bit, once with zero data and once with non-zero data, separate framing error from break. Back-to-back writes and back-to-back received frames exercise both overrun paths, and the status reads that follow show which flags clear and which remain.

// File: rtl/mmio_serial_pkg.sv
package mmio_serial_pkg;

  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 5;
  localparam int IDX_W      = 3;
  localparam int DIV_W      = 16;
  localparam int CTRL_W     = 13;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int FCNT_W     = $clog2(FRAME_BITS + 1);
  localparam int BIDX_W     = $clog2(BYTE_W);

  // register indices (address bits [4:2])
  localparam logic [IDX_W-1:0] IDX_RXD  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_TXD  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DIV  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_EOP  = 3'd5;

  // status bit positions; control enables share them
  localparam int ST_PE   = 0;
  localparam int ST_FE   = 1;
  localparam int ST_BRK  = 2;
  localparam int ST_ROE  = 3;
  localparam int ST_TOE  = 4;
  localparam int ST_TMT  = 5;
  localparam int ST_TRDY = 6;
  localparam int ST_RRDY = 7;
  localparam int ST_ERR  = 8;
  localparam int ST_DCTS = 10;

  localparam logic [BUS_W-1:0] IRQ_MASK = 32'h0000_05FF;

  typedef struct packed {
    logic              txLoad;
    logic [BYTE_W-1:0] txByte;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              rxDone;
    logic [BYTE_W-1:0] rxByte;
    logic              rxStopBad;
    logic              txBusy;
  } dpEvent_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_RELEASE
  } rxState_t;

endpackage

// File: rtl/mmio_serial_ctrl.sv
module mmio_serial_ctrl
  import mmio_serial_pkg::*;
#(
  parameter int DIV_RESET = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              irq,
  output ctrlStrobe_t       strobe,
  output logic [DIV_W-1:0]  divisor,
  input  dpEvent_t          dpEvt
);

  logic [IDX_W-1:0]  idx;
  logic              unusedAddrLow;
  logic [BYTE_W-1:0] rxDataQ, txDataQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic [DIV_W-1:0]  divQ;
  logic [BUS_W-1:0]  eopQ;
  logic              feQ, brkQ, roeQ, toeQ, rrdyQ;
  logic [BUS_W-1:0]  statusWord;
  logic [BUS_W-1:0]  ctrlWide;
  logic              wrTx, wrCtrl, wrDiv, wrEop;
  logic              rdRx, rdStat;

  assign idx           = addr[IDX_W+1:2];
  assign unusedAddrLow = ^addr[1:0];

  assign wrTx   = wrEn && (idx == IDX_TXD);
  assign wrCtrl = wrEn && (idx == IDX_CTRL);
  assign wrDiv  = wrEn && (idx == IDX_DIV);
  assign wrEop  = wrEn && (idx == IDX_EOP);
  assign rdRx   = rdEn && (idx == IDX_RXD);
  assign rdStat = rdEn && (idx == IDX_STAT);

  // status word assembly
  always_comb begin
    statusWord          = '0;
    statusWord[ST_FE]   = feQ;
    statusWord[ST_BRK]  = brkQ;
    statusWord[ST_ROE]  = roeQ;
    statusWord[ST_TOE]  = toeQ;
    statusWord[ST_TMT]  = !dpEvt.txBusy;
    statusWord[ST_TRDY] = !dpEvt.txBusy;
    statusWord[ST_RRDY] = rrdyQ;
    statusWord[ST_ERR]  = feQ | brkQ | roeQ | toeQ;
  end

  assign ctrlWide = {{(BUS_W-CTRL_W){1'b0}}, ctrlQ};
  assign irq      = |(statusWord & ctrlWide & IRQ_MASK);

  // strobes toward the datapath
  assign strobe.txLoad = wrTx && !dpEvt.txBusy;
  assign strobe.txByte = wrData[BYTE_W-1:0];
  assign divisor       = divQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxDataQ <= '0;
      txDataQ <= '0;
      ctrlQ   <= '0;
      divQ    <= DIV_W'(DIV_RESET);
      eopQ    <= '0;
      feQ     <= 1'b0;
      brkQ    <= 1'b0;
      roeQ    <= 1'b0;
      toeQ    <= 1'b0;
      rrdyQ   <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
      if (wrDiv)  divQ  <= wrData[DIV_W-1:0];
      if (wrEop)  eopQ  <= wrData;
      if (strobe.txLoad) txDataQ <= wrData[BYTE_W-1:0];

      // read side effects first, new events override them
      if (rdStat) begin
        feQ  <= 1'b0;
        brkQ <= 1'b0;
        roeQ <= 1'b0;
        toeQ <= 1'b0;
      end
      if (rdRx) rrdyQ <= 1'b0;

      if (wrTx && dpEvt.txBusy) toeQ <= 1'b1;

      if (dpEvt.rxDone) begin
        if (rrdyQ && !rdRx) begin
          roeQ <= 1'b1;
        end else begin
          rxDataQ <= dpEvt.rxByte;
          rrdyQ   <= 1'b1;
        end
        if (dpEvt.rxStopBad) begin
          feQ <= 1'b1;
          if (dpEvt.rxByte == '0) brkQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (idx)
      IDX_RXD:  rdData = {{(BUS_W-BYTE_W){1'b0}}, rxDataQ};
      IDX_TXD:  rdData = {{(BUS_W-BYTE_W){1'b0}}, txDataQ};
      IDX_STAT: rdData = statusWord;
      IDX_CTRL: rdData = ctrlWide;
      IDX_DIV:  rdData = {{(BUS_W-DIV_W){1'b0}}, divQ};
      IDX_EOP:  rdData = eopQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/mmio_serial_datapath.sv
module mmio_serial_datapath
  import mmio_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxLine,
  output logic             txLine,
  output dpEvent_t         dpEvt
);

  // transmit shifter
  logic [FRAME_BITS-1:0] txShiftQ;
  logic [DIV_W-1:0]      txCntQ;
  logic [FCNT_W-1:0]     txBitsQ;
  logic                  txBusyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShiftQ <= '1;
      txCntQ   <= '0;
      txBitsQ  <= '0;
      txBusyQ  <= 1'b0;
    end else if (strobe.txLoad) begin
      txShiftQ <= {1'b1, strobe.txByte, 1'b0};
      txCntQ   <= divisor;
      txBitsQ  <= FCNT_W'(FRAME_BITS);
      txBusyQ  <= 1'b1;
    end else if (txBusyQ) begin
      if (txCntQ == '0) begin
        txShiftQ <= {1'b1, txShiftQ[FRAME_BITS-1:1]};
        txCntQ   <= divisor;
        txBitsQ  <= txBitsQ - 1'b1;
        if (txBitsQ == FCNT_W'(1)) txBusyQ <= 1'b0;
      end else begin
        txCntQ <= txCntQ - 1'b1;
      end
    end
  end

  assign txLine = txShiftQ[0];

  // input synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxBit;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign rxBit = syncQ[SYNC_STAGES-1];

  // receive sampler
  rxState_t          rxStateQ;
  logic [DIV_W-1:0]  rxCntQ;
  logic [BIDX_W-1:0] rxIdxQ;
  logic [BYTE_W-1:0] rxShiftQ;
  logic              rxDoneQ, rxBadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxStateQ <= RX_IDLE;
      rxCntQ   <= '0;
      rxIdxQ   <= '0;
      rxShiftQ <= '0;
      rxDoneQ  <= 1'b0;
      rxBadQ   <= 1'b0;
    end else begin
      rxDoneQ <= 1'b0;
      case (rxStateQ)
        RX_IDLE: begin
          if (!rxBit) begin
            rxStateQ <= RX_START;
            rxCntQ   <= divisor >> 1;
          end
        end
        RX_START: begin
          if (rxCntQ != '0) begin
            rxCntQ <= rxCntQ - 1'b1;
          end else if (!rxBit) begin
            rxStateQ <= RX_DATA;
            rxCntQ   <= divisor;
            rxIdxQ   <= '0;
          end else begin
            rxStateQ <= RX_IDLE;
          end
        end
        RX_DATA: begin
          if (rxCntQ != '0) begin
            rxCntQ <= rxCntQ - 1'b1;
          end else begin
            rxShiftQ <= {rxBit, rxShiftQ[BYTE_W-1:1]};
            rxCntQ   <= divisor;
            rxIdxQ   <= rxIdxQ + 1'b1;
            if (rxIdxQ == BIDX_W'(BYTE_W-1)) rxStateQ <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (rxCntQ != '0) begin
            rxCntQ <= rxCntQ - 1'b1;
          end else begin
            rxDoneQ  <= 1'b1;
            rxBadQ   <= !rxBit;
            rxStateQ <= RX_RELEASE;
          end
        end
        RX_RELEASE: begin
          if (rxBit) rxStateQ <= RX_IDLE;
        end
        default: rxStateQ <= RX_IDLE;
      endcase
    end
  end

  assign dpEvt.rxDone    = rxDoneQ;
  assign dpEvt.rxByte    = rxShiftQ;
  assign dpEvt.rxStopBad = rxBadQ;
  assign dpEvt.txBusy    = txBusyQ;

endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
  import mmio_serial_pkg::*;
#(
  parameter int DIV_RESET   = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              irq,
  input  logic              rxLine,
  output logic              txLine
);

  ctrlStrobe_t      strobe;
  dpEvent_t         dpEvt;
  logic [DIV_W-1:0] divisor;

  mmio_serial_ctrl #(.DIV_RESET(DIV_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq),
    .strobe(strobe), .divisor(divisor), .dpEvt(dpEvt)
  );

  mmio_serial_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divisor(divisor),
    .rxLine(rxLine), .txLine(txLine), .dpEvt(dpEvt)
  );

endmodule

// File: rtl/mmio_serial_port_chk.sv
module mmio_serial_port_chk
  import mmio_serial_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              irq,
  input logic              txLine,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [BUS_W-1:0]  statusWord,
  input logic [BYTE_W-1:0] rxDataReg,
  input logic              rxDone,
  input logic              rxStopBad,
  input logic              txBusy
);

  logic [IDX_W-1:0] idx;
  assign idx = addr[IDX_W+1:2];

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((ctrlWord & CTRL_W'(IRQ_MASK)) != '0)); // R3

  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine); // R7

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx == IDX_RXD && !rxDone) |=> !statusWord[ST_RRDY]); // R4

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx == IDX_STAT && !rxDone && !wrEn) |=> (statusWord[4:0] == '0 && !statusWord[ST_ERR])); // R5

  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && statusWord[ST_RRDY] && !(rdEn && idx == IDX_RXD)) |=> (statusWord[ST_ROE] && $stable(rxDataReg))); // R9

  AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_TXD && txBusy) |=> statusWord[ST_TOE]); // R8

  AST_FRAMING_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxStopBad) |=> (statusWord[ST_FE] && statusWord[ST_ERR])); // R10

endmodule

bind mmio_serial_port mmio_serial_port_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .irq(irq), .txLine(txLine),
  .ctrlWord(u_ctrl.ctrlQ), .statusWord(u_ctrl.statusWord),
  .rxDataReg(u_ctrl.rxDataQ),
  .rxDone(dpEvt.rxDone), .rxStopBad(dpEvt.rxStopBad), .txBusy(dpEvt.txBusy)
);

// File: tb/mmio_serial_port_bench.sv
`timescale 1ns/1ps
module mmio_serial_port_bench;

  localparam int RESET_DIV = 15;
  localparam int FAST_DIV  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  logic        txLine;
  logic        rxLine;
  logic        loopOn = 1'b0;
  logic        drvLine = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  assign rxLine = loopOn ? txLine : drvLine;

  always #5 clk = ~clk;

  mmio_serial_port #(.DIV_RESET(RESET_DIV)) u_mmio_serial_port (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq),
    .rxLine(rxLine), .txLine(txLine)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(tag, v, exp);
  endtask

  // R7: sample each bit of a frame on the line
  task automatic txFrameCheck(input logic [7:0] b, input int div);
    logic expBit;
    busWrite(5'h04, {24'h0, b});
    for (int i = 0; i < 10; i++) begin
      if (i > 0) begin
        repeat (div + 1) @(posedge clk);
        @(negedge clk);
      end
      expBit = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      check("R7 tx bit", {31'h0, txLine}, {31'h0, expBit});
    end
    repeat (div + 1) @(posedge clk);
    @(negedge clk);
    readCheck("R7 idle after frame", 5'h08, 32'h60);
  endtask

  // bench-driven frame with FAST_DIV timing
  task automatic rxFrameDrive(input logic [7:0] b, input logic stopVal);
    logic [9:0] f;
    f = {stopVal, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      drvLine = f[i];
      repeat (FAST_DIV) @(negedge clk);
    end
    @(negedge clk);
    drvLine = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  function automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      void'(finishRun());
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    check("R2 irq", {31'h0, irq}, 32'h0);
    check("R2 txLine", {31'h0, txLine}, 32'h1);
    readCheck("R2 status", 5'h08, 32'h60);
    readCheck("R2 control", 5'h0C, 32'h0);
    readCheck("R2 divisor", 5'h10, RESET_DIV);

    // R11 / R1 storage, masking and decode
    busWrite(5'h0C, 32'hFFFF_FFFF);
    readCheck("R11 control mask", 5'h0C, 32'h1FFF);
    readCheck("R1 low address bits ignored", 5'h0E, 32'h1FFF);
    check("R3 irq with all enables", {31'h0, irq}, 32'h1);
    busWrite(5'h0C, 32'h0);
    busWrite(5'h10, 32'hABCD_1234);
    readCheck("R11 divisor", 5'h10, 32'h1234);
    busWrite(5'h14, 32'hDEAD_BEEF);
    readCheck("R11 eop word", 5'h14, 32'hDEAD_BEEF);
    readCheck("R1 index 6", 5'h18, 32'h0);
    readCheck("R1 index 7", 5'h1C, 32'h0);
    check("R11 line untouched", {31'h0, txLine}, 32'h1);

    // R3 interrupt mask
    busWrite(5'h0C, 32'h0020); @(negedge clk);
    check("R3 tx-empty enable", {31'h0, irq}, 32'h1);
    busWrite(5'h0C, 32'h0040); @(negedge clk);
    check("R3 tx-ready enable", {31'h0, irq}, 32'h1);
    busWrite(5'h0C, 32'h0200); @(negedge clk);
    check("R3 bit9 no irq", {31'h0, irq}, 32'h0);
    busWrite(5'h0C, 32'h0800); @(negedge clk);
    check("R3 bit11 no irq", {31'h0, irq}, 32'h0);
    busWrite(5'h0C, 32'h1000); @(negedge clk);
    check("R3 bit12 no irq", {31'h0, irq}, 32'h0);
    busWrite(5'h0C, 32'h0080); @(negedge clk);
    check("R3 rx-ready enable, nothing held", {31'h0, irq}, 32'h0);
    busWrite(5'h0C, 32'h0);

    // R6 writes to read-only words
    busWrite(5'h08, 32'hFFFF_FFFF);
    readCheck("R6 status write ignored", 5'h08, 32'h60);
    busWrite(5'h00, 32'h0000_00FF);
    readCheck("R6 rx write ignored", 5'h00, 32'h0);

    // R7 frame shape at two divisors
    busWrite(5'h10, FAST_DIV);
    txFrameCheck(8'h00, FAST_DIV);
    txFrameCheck(8'hFF, FAST_DIV);
    txFrameCheck(8'hA5, FAST_DIV);
    txFrameCheck(8'h5A, FAST_DIV);
    txFrameCheck(8'h01, FAST_DIV);
    txFrameCheck(8'h80, FAST_DIV);
    busWrite(5'h10, 6);
    txFrameCheck(8'h3C, 6);
    txFrameCheck(8'hC3, 6);
    busWrite(5'h10, FAST_DIV);

    // R8 transmit overrun, second byte dropped
    loopOn = 1'b1;
    repeat (4) @(negedge clk);
    busWrite(5'h04, 32'h5A);
    busWrite(5'h04, 32'hC3);
    readCheck("R8 overrun flag, busy", 5'h08, 32'h110);
    repeat (60) @(negedge clk);
    readCheck("R8 flag cleared, byte in", 5'h08, 32'hE0);
    readCheck("R8 first byte kept", 5'h00, 32'h5A);

    // R9 / R4 loopback sweep over all byte values
    busWrite(5'h0C, 32'h0080);
    for (int b = 0; b < 256; b++) begin
      busWrite(5'h04, b);
      repeat (50) @(negedge clk);
      check("R3 irq on rx ready", {31'h0, irq}, 32'h1);
      readCheck("R9 rx ready", 5'h08, 32'hE0);
      readCheck("R4 rx byte", 5'h00, b);
      check("R4 irq drops after read", {31'h0, irq}, 32'h0);
      readCheck("R4 rx ready cleared", 5'h08, 32'h60);
    end
    busWrite(5'h0C, 32'h0);

    // R9 receive overrun, R5 status read keeps rx ready
    busWrite(5'h04, 32'h11);
    repeat (50) @(negedge clk);
    busWrite(5'h04, 32'h22);
    repeat (50) @(negedge clk);
    readCheck("R9 overrun status", 5'h08, 32'h1E8);
    readCheck("R5 errors cleared, ready kept", 5'h08, 32'hE0);
    readCheck("R9 held byte kept", 5'h00, 32'h11);
    readCheck("R9 all clear", 5'h08, 32'h60);

    // R10 framing error and break
    loopOn = 1'b0;
    repeat (4) @(negedge clk);
    rxFrameDrive(8'h00, 1'b0);
    readCheck("R10 break with framing", 5'h08, 32'h1E6);
    readCheck("R10 zero byte", 5'h00, 32'h0);
    readCheck("R5 cleared", 5'h08, 32'h60);
    rxFrameDrive(8'h96, 1'b0);
    readCheck("R10 framing only", 5'h08, 32'h1E2);
    readCheck("R10 data byte", 5'h00, 32'h96);
    readCheck("R5 cleared again", 5'h08, 32'h60);
    rxFrameDrive(8'h3B, 1'b1);
    readCheck("R9 good frame", 5'h08, 32'hE0);
    readCheck("R4 good byte", 5'h00, 32'h3B);

    finished = 1'b1;
    void'(finishRun());
    $finish;
  end

endmodule